// File: doc/BRIEF.md
# Register Write-Protect Key Gate

This block sits beside a peripheral register file and decides whether bus writes to it may take effect. After reset the file is locked: every write to a protected offset is discarded, while reads always work. Software opens the file by writing a first 32-bit magic value to one key register and then a second 32-bit magic value to another key register, in that order. Writing any other value to either key register, zero included, closes the file again and restarts the sequence.

The gate watches a simple 32-bit register bus (write strobe, byte address, write data and a combinational read data path). It drives a write qualifier that the protected registers AND into their own write enables. It also holds three 32-bit scratch words that are guarded by the same lock and can be read back at any time.

Top module: `keygate_unlock`

## Requirements
- R1: After reset the gate is locked, so `prot_we_o` stays low for a write to any offset, and all three scratch words read 0.
- R2: A write of 0x83E70B13 to offset 0x6C followed directly by a write of 0x95A4F1E0 to offset 0x70 opens the gate from the next cycle on.
- R3: The two keys in the opposite order (0x70 first, then 0x6C) do not open the gate.
- R4: Any write to 0x6C with a value other than 0x83E70B13, or to 0x70 with a value other than 0x95A4F1E0 or without the correct first key just before it, leaves the gate locked and the sequence restarts.
- R5: While open, writing 0 to the key registers returns the gate to the locked state.
- R6: While locked, writes to the scratch words at 0x60, 0x64 and 0x68 are dropped and their contents stay unchanged.
- R7: While open, a write to 0x60, 0x64 or 0x68 stores the data, and each word reads back its own value whether the gate is open or locked.
- R8: Reading either key register (0x6C or 0x70) returns 0; key writes are always accepted.
- R9: `prot_we_o` is high only in a cycle where `bus_we` is high, the gate is open and the address is not a key register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_addr | input | 8 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| prot_we_o | output | 1 | Write qualifier for the protected registers |

## Verification
The assertions take for granted that `bus_we`, `bus_addr` and `bus_wdata` are stable and known around each rising edge and that a write lasts exactly one strobe cycle. The bench changes these inputs only a little after each rising edge and deasserts the strobe between writes, so every key write is seen once. The two-write key sweep covers every pair drawn from both key offsets and four values, with the expected lock state worked out from the ordering rule alone.

// File: rtl/keygate_pkg.sv
// Package: shared types and key constants for the write-protect key gate.
// Assumes a 32-bit data bus; key values are fixed at design time.
package keygate_pkg;

    typedef enum logic [1:0] {
        KG_LOCKED = 2'd0,
        KG_HALF   = 2'd1,
        KG_OPEN   = 2'd2
    } kg_state_t;

    localparam logic [31:0] KG_KEY_A = 32'h83E7_0B13;
    localparam logic [31:0] KG_KEY_B = 32'h95A4_F1E0;

endpackage

// File: rtl/keygate_fsm.sv
// Module: keygate_fsm
// Tracks the two-step key sequence and reports whether the gate is open.
// Assumes wr_a and wr_b are never high together (distinct offsets).
module keygate_fsm
    import keygate_pkg::*;
#(
    parameter int          DATA_W = 32,
    parameter logic [31:0] KEY_A  = KG_KEY_A,
    parameter logic [31:0] KEY_B  = KG_KEY_B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_a,
    input  logic              wr_b,
    input  logic [DATA_W-1:0] wdata,
    output logic              open_o
);

    kg_state_t st;

    // Step the key sequence on each key write; any mismatch relocks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= KG_LOCKED;
        end else if (wr_a) begin
            st <= (wdata == KEY_A[DATA_W-1:0]) ? KG_HALF : KG_LOCKED;
        end else if (wr_b) begin
            st <= (st == KG_HALF && wdata == KEY_B[DATA_W-1:0]) ? KG_OPEN : KG_LOCKED;
        end
    end

    // Gate is open only in the final state.
    always_comb open_o = (st == KG_OPEN);

    // R1: reset leaves the gate locked.
    a_r1_reset_locked: assert property (@(posedge clk) !rst_n |=> !open_o);

    // R2: the gate opens only right after a correct second-key write.
    a_r2_open_after_key_b: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(open_o) |-> $past(wr_b && wdata == KEY_B[DATA_W-1:0]));

    // R4: a wrong second key always leaves the gate locked.
    a_r4_bad_key_b_locks: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_b && wdata != KEY_B[DATA_W-1:0]) |=> !open_o);

    // R5: any first-key write, zero included, closes the gate.
    a_r5_key_a_closes: assert property (@(posedge clk) disable iff (!rst_n)
        wr_a |=> !open_o);

endmodule

// File: rtl/keygate_scratch.sv
// Module: keygate_scratch
// A small bank of protected scratch words with an address-decoded read port.
// Assumes the caller gates wr with the unlock state; word offsets are 4-byte aligned.
module keygate_scratch #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int WORDS  = 3,
    parameter int BASE   = 'h60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              hit_o,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int STRIDE = 4;

    logic [DATA_W-1:0] mem [WORDS];
    logic [WORDS-1:0]  word_hit;

    for (genvar i = 0; i < WORDS; i++) begin : g_word
        // Decode this word's offset.
        always_comb word_hit[i] = (addr == ADDR_W'(BASE + STRIDE * i));

        // Store data on a qualified write to this word.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem[i] <= '0;
            end else if (wr && word_hit[i]) begin
                mem[i] <= wdata;
            end
        end

        // R6: a word not written by a qualified write keeps its value.
        a_r6_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr && word_hit[i]) |=> $stable(mem[i]));
    end

    // Select the addressed word for the read port.
    always_comb begin
        rdata_o = '0;
        for (int j = 0; j < WORDS; j++) begin
            if (word_hit[j]) rdata_o = mem[j];
        end
    end

    // Flag that the address falls on a scratch word.
    always_comb hit_o = |word_hit;

endmodule

// File: rtl/keygate_unlock.sv
// Module: keygate_unlock (top)
// Decodes the key offsets, runs the key sequence, qualifies writes to the
// protected file and hosts the scratch words. Assumes one write per strobe cycle.
module keygate_unlock
    import keygate_pkg::*;
#(
    parameter int          ADDR_W     = 8,
    parameter int          DATA_W     = 32,
    parameter int          SCR_WORDS  = 3,
    parameter int          SCR_BASE   = 'h60,
    parameter int          KEY_A_OFS  = 'h6C,
    parameter int          KEY_B_OFS  = 'h70,
    parameter logic [31:0] KEY_A      = KG_KEY_A,
    parameter logic [31:0] KEY_B      = KG_KEY_B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              prot_we_o
);

    logic              hit_a, hit_b, key_hit;
    logic              gate_open;
    logic              scr_hit;
    logic [DATA_W-1:0] scr_rdata;

    // Decode the two key offsets.
    always_comb begin
        hit_a   = (bus_addr == ADDR_W'(KEY_A_OFS));
        hit_b   = (bus_addr == ADDR_W'(KEY_B_OFS));
        key_hit = hit_a | hit_b;
    end

    keygate_fsm #(
        .DATA_W (DATA_W),
        .KEY_A  (KEY_A),
        .KEY_B  (KEY_B)
    ) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_a   (bus_we && hit_a),
        .wr_b   (bus_we && hit_b),
        .wdata  (bus_wdata),
        .open_o (gate_open)
    );

    // Qualify non-key writes with the open state.
    always_comb prot_we_o = bus_we && gate_open && !key_hit;

    keygate_scratch #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .WORDS  (SCR_WORDS),
        .BASE   (SCR_BASE)
    ) u_scr (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (bus_addr),
        .wr      (prot_we_o),
        .wdata   (bus_wdata),
        .hit_o   (scr_hit),
        .rdata_o (scr_rdata)
    );

    // Return scratch data; keys and other offsets read as zero.
    always_comb bus_rdata = scr_hit ? scr_rdata : '0;

    // R9: no qualified write while the key sequence has not completed.
    a_r9_qual_needs_open: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_open |-> !prot_we_o);

    // R8: a key offset never returns data.
    always_comb begin
        if (rst_n && key_hit) begin
            a_r8_key_reads_zero: assert (bus_rdata == '0);
        end
    end

endmodule

// File: tb/tb_keygate_unlock.sv
`timescale 1ns/1ps
module tb_keygate_unlock;

    localparam logic [31:0] KA = 32'h83E7_0B13;
    localparam logic [31:0] KB = 32'h95A4_F1E0;
    localparam logic [7:0]  OA = 8'h6C;
    localparam logic [7:0]  OB = 8'h70;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        prot_we_o;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    keygate_unlock dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .prot_we_o (prot_we_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_we = 1'b0;
    endtask

    // Probe the qualifier with a write to an offset outside the block.
    task automatic probe(input string tag, input logic exp);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 8'h00; bus_wdata = 32'h0;
        #1 check(tag, {31'b0, prot_we_o}, {31'b0, exp});
        @(posedge clk);
        #1 bus_we = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_we = 1'b0; bus_addr = a;
        #1 check(tag, bus_rdata, exp);
    endtask

    initial begin
        #(200000 * 5);
        total++; bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] vals [4];
        logic [7:0]  offs [2];
        vals[0] = KA; vals[1] = KB; vals[2] = 32'h0; vals[3] = 32'h1234_5678;
        offs[0] = OA; offs[1] = OB;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: locked after reset, scratch cleared
        probe("R1 locked after reset", 1'b0);
        for (int i = 0; i < 3; i++) rd("R1 scratch reset", 8'(8'h60 + 4 * i), 32'h0);

        // R8: key offsets read zero
        rd("R8 key A reads 0", OA, 32'h0);
        rd("R8 key B reads 0", OB, 32'h0);

        // R6: locked writes dropped
        for (int i = 0; i < 3; i++) wr(8'(8'h60 + 4 * i), 32'hDEAD_0000 + i);
        for (int i = 0; i < 3; i++) rd("R6 locked write dropped", 8'(8'h60 + 4 * i), 32'h0);

        // R2 R3 R4: sweep every pair of two key writes
        for (int p = 0; p < 8; p++) begin
            for (int q = 0; q < 8; q++) begin
                logic exp_open;
                wr(OA, 32'h0);
                wr(offs[p / 4], vals[p % 4]);
                wr(offs[q / 4], vals[q % 4]);
                exp_open = (offs[p / 4] == OA) && (vals[p % 4] == KA) &&
                           (offs[q / 4] == OB) && (vals[q % 4] == KB);
                probe("R2 R3 R4 key pair sweep", exp_open);
            end
        end

        // R3: reverse order
        wr(OA, 32'h0);
        wr(OB, KB); wr(OA, KA);
        probe("R3 reverse order stays locked", 1'b0);

        // R4: correct first key, then a stray write between keys is fine, wrong A restarts
        wr(OA, KA); wr(OA, 32'h5555_AAAA); wr(OB, KB);
        probe("R4 wrong first key restarts", 1'b0);

        // R7: open, write and read back
        wr(OA, KA); wr(OB, KB);
        probe("R2 open", 1'b1);
        for (int i = 0; i < 3; i++) wr(8'(8'h60 + 4 * i), 32'hC0DE_0100 * (i + 1));
        for (int i = 0; i < 3; i++) rd("R7 scratch stored", 8'(8'h60 + 4 * i), 32'hC0DE_0100 * (i + 1));

        // R9: key write never qualified even when open
        @(negedge clk);
        bus_we = 1'b1; bus_addr = OB; bus_wdata = KB;
        #1 check("R9 key write not qualified", {31'b0, prot_we_o}, 32'h0);
        bus_addr = 8'h64;
        #0.5 check("R9 open write qualified", {31'b0, prot_we_o}, 32'h1);
        bus_we = 1'b0;
        #0.2;

        // R5: zero keys relock, scratch still readable and unchanged
        wr(OA, KA); wr(OB, KB);
        probe("R5 open before relock", 1'b1);
        wr(OA, 32'h0); wr(OB, 32'h0);
        probe("R5 zero keys relock", 1'b0);
        for (int i = 0; i < 3; i++) wr(8'(8'h60 + 4 * i), 32'hFFFF_FFFF);
        for (int i = 0; i < 3; i++) rd("R7 R6 readable while locked", 8'(8'h60 + 4 * i), 32'hC0DE_0100 * (i + 1));
        rd("R8 key reads 0 after writes", OB, 32'h0);

        // R4: wrong second key while open relocks
        wr(OA, KA); wr(OB, KB);
        wr(OB, 32'h0000_0001);
        probe("R4 bad second key relocks", 1'b0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule